// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block behaves as a small serial EEPROM of 64 sixteen-bit words for a host that toggles chip select, serial clock and data-in by software. The three input pins are brought into the system clock domain through a two-flop synchronizer, and their edges are detected there. After a start bit the device takes in a two-bit opcode and an address. It then reads a word out serially, or it programs the array with a write, an erase, a write-all or an erase-all. Two further commands lock and unlock programming.

Programming time is modelled by a busy counter. Its length for each kind of operation is a parameter given in system clock cycles. Between commands the data-out pin shows whether the device is ready. The initial array contents come in through a parallel preload port that works only while reset is held. A parallel peek port lets a testbench read any word directly.

The controller has six states: IDLE (CS low, or a command has finished), START (CS high, waiting for the start bit), CMD (taking in opcode and address), READ (shifting out data), WDATA (taking in the data word of a write or write-all) and PROG (programming in progress, waiting for CS to fall). The transitions are as follows. IDLE goes to START on a CS rising edge. START goes to CMD on an accepted start bit. CMD goes to READ, WDATA, PROG or IDLE when the last address bit arrives. WDATA goes to PROG or IDLE after the sixteenth data bit. Every state goes to IDLE on a CS falling edge.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the device is in IDLE, `do_o` is 1, programming is locked and the device is not busy.
- R2: A CS falling edge returns the device to IDLE from any state. A half-received command is dropped, and the next CS rising edge starts a new frame.
- R3: In START, the start bit is taken only on an SK rising edge with DI high while the device is not busy. SK edges with DI low are ignored. An SK rising edge that arrives in the same system clock as the CS rising edge is ignored.
- R4: The frame is a 1 start bit, then 2 opcode bits, then 6 address bits, all MSB first. The opcodes are: 10 read, 01 write, 11 erase. For opcode 00, the top two address bits select the operation: 00 lock, 01 write-all, 10 erase-all, 11 unlock.
- R5: Programming is locked after reset. A write, erase, write-all or erase-all issued while locked leaves the array unchanged, does not set busy, and returns the device to IDLE.
- R6: After the last address bit of a read, `do_o` is a dummy 0. Each following SK rising edge presents the next bit of the addressed word, MSB first. After 16 bits, `do_o` is 1.
- R7: A write takes in exactly 16 data bits, MSB first, and replaces the addressed word. It then keeps the device busy for T_WRITE cycles.
- R8: An erase sets the addressed word to all ones and keeps the device busy for T_ERASE cycles.
- R9: Write-all ANDs its 16-bit data word into every word of the array. Erase-all sets every word to all ones. Each keeps the device busy for T_ALL cycles.
- R10: In START, `do_o` is 1 when the device is ready and 0 when it is busy. In IDLE, CMD, WDATA and PROG, `do_o` is 1.
- R11: The preload port writes the array only while `rst_n` is low, and is ignored afterwards. The peek port returns any word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select from host (asynchronous) |
| sk_i | input | 1 | Serial clock from host (asynchronous) |
| di_i | input | 1 | Serial data from host (asynchronous) |
| do_o | output | 1 | Serial data out / ready status; 1 when not driven |
| pre_we_i | input | 1 | Preload write strobe, honoured only in reset |
| pre_addr_i | input | 6 | Preload word address |
| pre_data_i | input | 16 | Preload word data |
| peek_addr_i | input | 6 | Peek port word address |
| peek_data_o | output | 16 | Peek port word data |

## Verification
A wrong state, bit count or lock flag shows up at `do_o` within one SK period. It appears as a missing dummy zero, a shifted read word, or a ready level where ones were expected. A wrong programming result shows up at the peek port as soon as the command completes. A wrong busy duration shows up at the next CS pulse, as a ready level seen too early or too late. The bench therefore samples `do_o` at the end of every SK phase of interest and compares the whole array against its model after each command.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_CMD,
        ST_READ,
        ST_WDATA,
        ST_PROG
    } mw_state_e;

    typedef enum logic [2:0] {
        AOP_NONE,
        AOP_WRITE,
        AOP_ERASE,
        AOP_WALL,
        AOP_EALL
    } mw_arr_op_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_WALL   = 2'b01;
    localparam logic [1:0] SUB_EALL   = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_eeprom_sync.sv
module mw_eeprom_sync #(
    parameter int NSIG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] pin_i,
    output logic [NSIG-1:0] lvl_o,
    output logic [NSIG-1:0] rise_o,
    output logic [NSIG-1:0] fall_o
);
    logic [NSIG-1:0] meta_q;
    logic [NSIG-1:0] sync_q;
    logic [NSIG-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar g = 0; g < NSIG; g++) begin : g_edge
        assign rise_o[g] = sync_q[g] & ~prev_q[g];
        assign fall_o[g] = ~sync_q[g] & prev_q[g];
    end

    assign lvl_o = sync_q;

endmodule

// File: rtl/mw_eeprom_busy.sv
module mw_eeprom_busy #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] dur_i,
    output logic          busy_o
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= dur_i;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy_o = (left_q != '0);

    p_busy_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/mw_eeprom_array.sv
module mw_eeprom_array
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we_i,
    input  logic [ADDR_W-1:0] pre_addr_i,
    input  logic [DATA_W-1:0] pre_data_i,
    input  mw_arr_op_e        op_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [DATA_W-1:0] op_data_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic [DATA_W-1:0] fetch_data_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (!rst_n) begin
                if (pre_we_i && pre_addr_i == ADDR_W'(w)) mem[w] <= pre_data_i;
            end else begin
                unique case (op_i)
                    AOP_WRITE: if (op_addr_i == ADDR_W'(w)) mem[w] <= op_data_i;
                    AOP_ERASE: if (op_addr_i == ADDR_W'(w)) mem[w] <= '1;
                    AOP_WALL:  mem[w] <= mem[w] & op_data_i;
                    AOP_EALL:  mem[w] <= '1;
                    default:   ;
                endcase
            end
        end
    end

    assign fetch_data_o = mem[fetch_addr_i];
    assign peek_data_o  = mem[peek_addr_i];

    p_hold_without_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == AOP_NONE) |=> $stable(mem[0]));

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int T_WRITE = 1750,
    parameter int T_ERASE = 1000,
    parameter int T_ALL   = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    output logic              do_o,
    input  logic              pre_we_i,
    input  logic [ADDR_W-1:0] pre_addr_i,
    input  logic [DATA_W-1:0] pre_data_i,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);
    localparam int CMD_BITS = 2 + ADDR_W;
    localparam int CNT_MAX  = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
    localparam int CNT_W    = $clog2(CNT_MAX) + 1;
    localparam int T_MAX0   = (T_WRITE > T_ERASE) ? T_WRITE : T_ERASE;
    localparam int T_MAX    = (T_MAX0 > T_ALL) ? T_MAX0 : T_ALL;
    localparam int BCW      = $clog2(T_MAX + 1);

    // Synchronized pins: bit 2 = CS, bit 1 = SK, bit 0 = DI
    logic [2:0] lvl, rise, fall;
    logic cs_rise, cs_fall, sk_rise, di_s;

    mw_eeprom_sync #(.NSIG(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({cs_i, sk_i, di_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign cs_rise = rise[2];
    assign cs_fall = fall[2];
    assign sk_rise = rise[1];
    assign di_s    = lvl[0];

    mw_state_e state, nxt;

    logic [CNT_W-1:0]    cnt_q;
    logic [CMD_BITS-1:0] cmd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wsh_q;
    logic [DATA_W-1:0]   rsh_q;
    logic                rd_first_q;
    logic                is_wall_q;
    logic                locked_q;

    logic [CMD_BITS-1:0] cmd_next;
    logic [1:0]          opc;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [1:0]          sub;
    logic [DATA_W-1:0]   wnext;

    assign cmd_next = {cmd_q[CMD_BITS-2:0], di_s};
    assign opc      = cmd_next[CMD_BITS-1:ADDR_W];
    assign cmd_addr = cmd_next[ADDR_W-1:0];
    assign sub      = cmd_addr[ADDR_W-1:ADDR_W-2];
    assign wnext    = {wsh_q[DATA_W-2:0], di_s};

    logic              cmd_done, wdat_done;
    logic              lock_set, lock_clr;
    logic              busy, busy_start;
    logic [BCW-1:0]    busy_dur;
    mw_arr_op_e        arr_op;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_data;
    logic [DATA_W-1:0] fetch_data;

    assign cmd_done  = (state == ST_CMD) && sk_rise && (cnt_q == CNT_W'(CMD_BITS - 1));
    assign wdat_done = (state == ST_WDATA) && sk_rise && (cnt_q == CNT_W'(DATA_W - 1));

    // Next-state and command control
    always_comb begin
        nxt        = state;
        lock_set   = 1'b0;
        lock_clr   = 1'b0;
        busy_start = 1'b0;
        busy_dur   = '0;
        arr_op     = AOP_NONE;
        arr_addr   = addr_q;
        arr_data   = wnext;
        if (cs_fall) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_rise) nxt = ST_START;
                end
                ST_START: begin
                    if (sk_rise && di_s && !busy) nxt = ST_CMD;
                end
                ST_CMD: begin
                    if (cmd_done) begin
                        unique case (opc)
                            OPC_READ:  nxt = ST_READ;
                            OPC_WRITE: nxt = ST_WDATA;
                            OPC_ERASE: begin
                                if (locked_q) begin
                                    nxt = ST_IDLE;
                                end else begin
                                    nxt        = ST_PROG;
                                    arr_op     = AOP_ERASE;
                                    arr_addr   = cmd_addr;
                                    busy_start = 1'b1;
                                    busy_dur   = BCW'(T_ERASE);
                                end
                            end
                            default: begin
                                unique case (sub)
                                    SUB_LOCK: begin
                                        lock_set = 1'b1;
                                        nxt      = ST_IDLE;
                                    end
                                    SUB_UNLOCK: begin
                                        lock_clr = 1'b1;
                                        nxt      = ST_IDLE;
                                    end
                                    SUB_WALL: nxt = ST_WDATA;
                                    default: begin
                                        if (locked_q) begin
                                            nxt = ST_IDLE;
                                        end else begin
                                            nxt        = ST_PROG;
                                            arr_op     = AOP_EALL;
                                            busy_start = 1'b1;
                                            busy_dur   = BCW'(T_ALL);
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_WDATA: begin
                    if (wdat_done) begin
                        if (locked_q) begin
                            nxt = ST_IDLE;
                        end else begin
                            nxt        = ST_PROG;
                            busy_start = 1'b1;
                            arr_op     = is_wall_q ? AOP_WALL : AOP_WRITE;
                            busy_dur   = is_wall_q ? BCW'(T_ALL) : BCW'(T_WRITE);
                        end
                    end
                end
                ST_READ, ST_PROG: ;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shift registers, counters and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cmd_q      <= '0;
            addr_q     <= '0;
            wsh_q      <= '0;
            rsh_q      <= '0;
            rd_first_q <= 1'b0;
            is_wall_q  <= 1'b0;
            locked_q   <= 1'b1;
        end else begin
            if (lock_set) locked_q <= 1'b1;
            if (lock_clr) locked_q <= 1'b0;
            if (state == ST_START && nxt == ST_CMD) begin
                cnt_q <= '0;
                cmd_q <= '0;
            end
            if (state == ST_CMD && sk_rise) begin
                cmd_q <= cmd_next;
                cnt_q <= cnt_q + 1'b1;
                if (cmd_done) begin
                    cnt_q      <= '0;
                    addr_q     <= cmd_addr;
                    wsh_q      <= '0;
                    rsh_q      <= '0;
                    rd_first_q <= 1'b1;
                    is_wall_q  <= (opc == OPC_EXT);
                end
            end
            if (state == ST_WDATA && sk_rise) begin
                wsh_q <= wnext;
                cnt_q <= cnt_q + 1'b1;
            end
            if (state == ST_READ && sk_rise) begin
                rd_first_q <= 1'b0;
                if (rd_first_q) rsh_q <= fetch_data;
                else            rsh_q <= {rsh_q[DATA_W-2:0], 1'b1};
            end
        end
    end

    // Output process
    always_comb begin
        unique case (state)
            ST_START: do_o = ~busy;
            ST_READ:  do_o = rsh_q[DATA_W-1];
            default:  do_o = 1'b1;
        endcase
    end

    mw_eeprom_busy #(.CW(BCW)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (busy_start),
        .dur_i   (busy_dur),
        .busy_o  (busy)
    );

    mw_eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .pre_we_i     (pre_we_i),
        .pre_addr_i   (pre_addr_i),
        .pre_data_i   (pre_data_i),
        .op_i         (arr_op),
        .op_addr_i    (arr_addr),
        .op_data_i    (arr_data),
        .fetch_addr_i (addr_q),
        .fetch_data_o (fetch_data),
        .peek_addr_i  (peek_addr_i),
        .peek_data_o  (peek_data_o)
    );

    p_cs_fall_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (state == ST_IDLE));

    p_start_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && $past(state) == ST_START) |-> $past(!busy && di_s));

    p_locked_no_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!locked_q));

    p_busy_in_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (state == ST_PROG));

    p_read_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) != ST_READ) |-> !do_o);

endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;
    localparam int TW = 120;
    localparam int TE = 80;
    localparam int TA = 300;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_w;
    logic pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [DW-1:0] pre_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model [NW];

    always #2 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .T_WRITE(TW), .T_ERASE(TE), .T_ALL(TA)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_w),
        .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data),
        .peek_addr_i(peek_addr), .peek_data_o(peek_data)
    );

    function automatic logic [DW-1:0] seed_word(int i);
        return DW'(i * 16'h0123) ^ 16'hA5C3;
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: do=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_array(input string req);
        int bad = -1;
        checks++;
        for (int a = 0; a < NW; a++) begin
            peek_addr = AW'(a);
            #1;
            if (peek_data !== model[a] && bad < 0) begin
                bad = a;
                errors++;
                $display("FAIL %s: word %0d = %h expected %h", req, a, peek_data, model[a]);
            end
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        cs = 1'b0; sk = 1'b0; di = 1'b0;
        wait_n(HALF);
    endtask

    task automatic cs_hi();
        cs = 1'b1;
        wait_n(HALF);
    endtask

    task automatic bit_out(input logic b);
        di = b;
        wait_n(HALF);
        sk = 1'b1;
        wait_n(HALF);
        sk = 1'b0;
    endtask

    task automatic frame(input logic [1:0] op, input logic [AW-1:0] a, input logic with_start);
        if (with_start) bit_out(1'b1);
        bit_out(op[1]);
        bit_out(op[0]);
        for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
        wait_n(HALF);
    endtask

    task automatic read_check(input string req, input logic [DW-1:0] w);
        check({req, " dummy"}, do_w, 1'b0);
        for (int k = 0; k < DW + 2; k++) begin
            sk = 1'b1;
            wait_n(HALF);
            check(req, do_w, (k < DW) ? w[DW-1-k] : 1'b1);
            sk = 1'b0;
            wait_n(HALF);
        end
    endtask

    task automatic send_data(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) bit_out(d[i]);
        wait_n(HALF);
    endtask

    task automatic busy_poll(input string req, input int t);
        cs_lo();
        cs_hi();
        check({req, " busy"}, do_w, 1'b0);
        wait_n(t + 20);
        check({req, " ready"}, do_w, 1'b1);
        cs_lo();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected end");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R11: preload while in reset
        wait_n(3);
        for (int a = 0; a < NW; a++) begin
            pre_we = 1'b1; pre_addr = AW'(a); pre_data = seed_word(a);
            model[a] = seed_word(a);
            wait_n(1);
        end
        pre_we = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 reset do", do_w, 1'b1);
        check_array("R11 preload");

        // R11: preload after reset ignored
        pre_we = 1'b1; pre_addr = 6'd5; pre_data = 16'h0000;
        wait_n(2);
        pre_we = 1'b0;
        check_array("R11 preload ignored");

        // R1/R10: ready status in START
        cs_hi();
        check("R10 ready", do_w, 1'b1);
        // R3: leading low bits ignored, then R4/R6 read of word 3
        bit_out(1'b0);
        bit_out(1'b0);
        frame(2'b10, 6'd3, 1'b1);
        read_check("R6 read w3", model[3]);
        cs_lo();
        check("R2 idle after read", do_w, 1'b1);

        // R5: write while locked is discarded
        cs_hi();
        frame(2'b01, 6'd7, 1'b1);
        check("R10 wdata do", do_w, 1'b1);
        send_data(16'h1234);
        check("R5 idle after locked write", do_w, 1'b1);
        cs_lo();
        cs_hi();
        check("R5 not busy", do_w, 1'b1);
        cs_lo();
        check_array("R5 locked write");

        // R4: unlock (opcode 00, top address bits 11)
        cs_hi();
        frame(2'b00, 6'b110000, 1'b1);
        cs_lo();

        // R7: write word 7
        cs_hi();
        frame(2'b01, 6'd7, 1'b1);
        send_data(16'h1234);
        check("R10 prog do", do_w, 1'b1);
        model[7] = 16'h1234;
        busy_poll("R7 write", TW);
        check_array("R7 write");

        // R8: erase word 3
        cs_hi();
        frame(2'b11, 6'd3, 1'b1);
        model[3] = 16'hFFFF;
        busy_poll("R8 erase", TE);
        check_array("R8 erase");

        // R3: SK rising with CS rising is ignored; normal read follows
        cs = 1'b1; sk = 1'b1; di = 1'b1;
        wait_n(HALF);
        sk = 1'b0;
        wait_n(HALF);
        frame(2'b10, 6'd7, 1'b1);
        read_check("R3 simultaneous edge", 16'h1234);
        cs_lo();

        // R4: read of highest address
        cs_hi();
        frame(2'b10, 6'd63, 1'b1);
        read_check("R4 read w63", model[63]);
        cs_lo();

        // R9: write-all ANDs into array
        cs_hi();
        frame(2'b00, 6'b010000, 1'b1);
        send_data(16'hF0F0);
        for (int a = 0; a < NW; a++) model[a] = model[a] & 16'hF0F0;
        busy_poll("R9 write-all", TA);
        check_array("R9 write-all");

        // R9: erase-all
        cs_hi();
        frame(2'b00, 6'b100000, 1'b1);
        for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;
        busy_poll("R9 erase-all", TA);
        check_array("R9 erase-all");

        cs_hi();
        frame(2'b00, 6'b010000, 1'b1);
        send_data(16'h5A5A);
        for (int a = 0; a < NW; a++) model[a] = 16'h5A5A;
        busy_poll("R9 write-all 2", TA);
        check_array("R9 write-all 2");

        // R2: CS falling mid-command drops the frame
        cs_hi();
        bit_out(1'b1);
        bit_out(1'b1);
        bit_out(1'b1);
        cs_lo();
        cs_hi();
        frame(2'b10, 6'd0, 1'b1);
        read_check("R2 abort then read", model[0]);
        cs_lo();

        // R5: lock (opcode 00, top bits 00), then erase is discarded
        cs_hi();
        frame(2'b00, 6'b000000, 1'b1);
        cs_lo();
        cs_hi();
        frame(2'b11, 6'd0, 1'b1);
        check("R5 idle after locked erase", do_w, 1'b1);
        cs_lo();
        cs_hi();
        check("R5 not busy after lock", do_w, 1'b1);
        cs_lo();
        check_array("R5 locked erase");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule